// File: doc/BRIEF.md
# Closed-Loop Chip Erase Sequencer

This block drives the whole-array erase of a command-driven parallel flash from the host side. On `start` it can first bring every byte to 00H. It does this by handing addresses one at a time to a separate byte-program sequencer. It then alternates erase pulses with a verify scan. Each pulse is a pair of 20H command writes followed by a timed wait. The scan checks bytes in ascending address order. Every byte gets its own A0H command write carrying the address, then a recovery wait, then a read that must return FFH.

When a byte fails verification, the sequencer issues another erase pulse. The scan then picks up at the failing byte instead of at address zero, so bytes already proven erased are not read again. The run ends once the last byte verifies or the pulse budget is used up. In both cases the sequencer writes 00H to put the array back in read mode, then reports `done` with a pass flag and, on failure, the offending address. Array depth, pulse length, recovery length and pulse limit are parameters counted in clock cycles.

The bus master port holds a request until the slave acknowledges it. The same port carries both command writes and verify reads.

Top module: `chip_erase_seq`

## Requirements
- R1: After reset, `done`, `pass`, `bus_req` and `pgm_req` are low.
- R2: With `skip_preprog` low, a start issues one byte-program request per address, in ascending order from 0 to DEPTH-1, with `pgm_data` = 00H. Requests are issued one at a time, and none overlaps a bus request; all of them complete before the first bus transaction.
- R3: With `skip_preprog` high, no byte-program request is issued, and the first bus transaction is an erase command.
- R4: If a byte-program completion returns `pgm_ok` low, no erase command is issued. The sequencer writes 00H, then signals `done` with `pass` low and `fail_addr` equal to that byte's address.
- R5: Every erase pulse is started by two back-to-back bus writes (`bus_we` = 1) of data 20H; a lone 20H write never occurs.
- R6: After the acknowledge of the second 20H write, `bus_req` stays low for exactly ERASE_CYC cycles, and the next transaction is an A0H write.
- R7: Every verify read (`bus_we` = 0) is preceded directly by an A0H write to the same address, with exactly RECOV_CYC cycles of `bus_req` low between them.
- R8: A verify read returning FFH moves the scan on: the next A0H write carries the address plus one.
- R9: A verify read returning any value other than FFH starts a new erase pulse. The first A0H write after that pulse carries the failing address.
- R10: When address DEPTH-1 verifies as FFH, the sequencer writes 00H, then raises `done` with `pass` high.
- R11: At most MAX_PULSES erase pulses are issued per run. If a byte still fails after the last allowed pulse, the sequencer writes 00H and reports `done` with `pass` low and `fail_addr` equal to that byte's address.
- R12: While `bus_req` is high and `bus_ack` is low, the request and its `bus_we`, `bus_addr` and `bus_wdata` stay unchanged into the next cycle.
- R13: `done` is high for exactly one cycle per run, and the 00H write is the last bus transaction before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| skip_preprog | input | 1 | Sampled at start; high skips the 00H preprogram pass |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Run result, valid from `done` until the next start |
| fail_addr | output | AW | Address that caused a failed run |
| bus_req | output | 1 | Bus transaction request, held until acknowledged |
| bus_we | output | 1 | 1 = command write, 0 = verify read |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | 8 | Command byte for writes |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` on a read |
| bus_ack | input | 1 | Transaction completes in this cycle |
| pgm_req | output | 1 | Byte-program request, held until `pgm_done` |
| pgm_addr | output | AW | Byte to program |
| pgm_data | output | 8 | Value to program (always 00H) |
| pgm_done | input | 1 | Byte-program sequence finished this cycle |
| pgm_ok | input | 1 | Byte-program outcome, valid with `pgm_done` |

## Verification
A wrong scan address or a lost resume point shows up at the very next A0H write, as an address that does not match the last read outcome. A miscounted timer shows up as a wrong count of quiet cycles before the next request. A wrong pulse counter only becomes visible at the end of the run, as a wrong `pass` or `fail_addr` or a pulse count above the limit. The bench therefore gives each byte its own number of pulses needed before it reads FFH. It checks every transaction as it completes, and it checks the result once `done` rises.

// File: rtl/ce_pkg.sv
package ce_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PRG, ST_ERS_A, ST_ERS_B, ST_ERS_WAIT,
    ST_VFY_CMD, ST_VFY_WAIT, ST_VFY_RD, ST_RDMODE, ST_FIN
  } ce_state_t;

  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_VERIFY = 8'hA0;
  localparam logic [7:0] CMD_READ   = 8'h00;
  localparam logic [7:0] ERASED     = 8'hFF;
endpackage

// File: rtl/ce_counter.sv
module ce_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)      q_d = '0;
    else if (inc) q_d = q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (clr || inc) q <= q_d;
  end
endmodule

// File: rtl/ce_timer.sv
module ce_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt, cnt_d;
  logic         cnt_en;

  assign zero   = (cnt == '0);
  assign cnt_en = load || !zero;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/chip_erase_seq.sv
module chip_erase_seq #(
  parameter int DEPTH      = 16,
  parameter int ERASE_CYC  = 10,
  parameter int RECOV_CYC  = 6,
  parameter int MAX_PULSES = 6,
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1,
  localparam int PW = $clog2(MAX_PULSES + 1),
  localparam int TMAX = (ERASE_CYC > RECOV_CYC) ? ERASE_CYC : RECOV_CYC,
  localparam int TW = (TMAX > 1) ? $clog2(TMAX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          skip_preprog,
  output logic          done,
  output logic          pass,
  output logic [AW-1:0] fail_addr,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  input  logic          bus_ack,
  output logic          pgm_req,
  output logic [AW-1:0] pgm_addr,
  output logic [7:0]    pgm_data,
  input  logic          pgm_done,
  input  logic          pgm_ok
);
  import ce_pkg::*;

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [PW-1:0] PULSE_LIM = PW'(MAX_PULSES);
  localparam logic [TW-1:0] ERS_LOAD  = TW'(ERASE_CYC - 1);
  localparam logic [TW-1:0] RCV_LOAD  = TW'(RECOV_CYC - 1);

  ce_state_t     state, state_d;
  logic [AW-1:0] addr_q;
  logic [PW-1:0] pulse_q;
  logic          addr_clr, addr_inc, pulse_clr, pulse_inc;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          pass_q, pass_set, fail_set, res_clr;
  logic [AW-1:0] fail_q;
  logic          at_last;

  ce_counter #(.W(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(addr_clr), .inc(addr_inc), .q(addr_q));

  ce_counter #(.W(PW)) u_pulse (
    .clk(clk), .rst_n(rst_n), .clr(pulse_clr), .inc(pulse_inc), .q(pulse_q));

  ce_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero));

  assign at_last = (addr_q == LAST_ADDR);

  always_comb begin
    state_d   = state;
    addr_clr  = 1'b0;
    addr_inc  = 1'b0;
    pulse_clr = 1'b0;
    pulse_inc = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = ERS_LOAD;
    pass_set  = 1'b0;
    fail_set  = 1'b0;
    res_clr   = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        addr_clr  = 1'b1;
        pulse_clr = 1'b1;
        res_clr   = 1'b1;
        state_d   = skip_preprog ? ST_ERS_A : ST_PRG;
      end
      ST_PRG: if (pgm_done) begin
        if (!pgm_ok) begin
          fail_set = 1'b1;
          state_d  = ST_RDMODE;
        end else if (at_last) begin
          addr_clr = 1'b1;
          state_d  = ST_ERS_A;
        end else begin
          addr_inc = 1'b1;
        end
      end
      ST_ERS_A: if (bus_ack) state_d = ST_ERS_B;
      ST_ERS_B: if (bus_ack) begin
        pulse_inc = 1'b1;
        tmr_load  = 1'b1;
        tmr_val   = ERS_LOAD;
        state_d   = ST_ERS_WAIT;
      end
      ST_ERS_WAIT: if (tmr_zero) state_d = ST_VFY_CMD;
      ST_VFY_CMD: if (bus_ack) begin
        tmr_load = 1'b1;
        tmr_val  = RCV_LOAD;
        state_d  = ST_VFY_WAIT;
      end
      ST_VFY_WAIT: if (tmr_zero) state_d = ST_VFY_RD;
      ST_VFY_RD: if (bus_ack) begin
        if (bus_rdata == ERASED) begin
          if (at_last) begin
            pass_set = 1'b1;
            state_d  = ST_RDMODE;
          end else begin
            addr_inc = 1'b1;
            state_d  = ST_VFY_CMD;
          end
        end else if (pulse_q == PULSE_LIM) begin
          fail_set = 1'b1;
          state_d  = ST_RDMODE;
        end else begin
          state_d = ST_ERS_A;
        end
      end
      ST_RDMODE: if (bus_ack) state_d = ST_FIN;
      ST_FIN:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      fail_q <= '0;
    end else begin
      if (res_clr || pass_set) pass_q <= pass_set;
      if (res_clr)             fail_q <= '0;
      else if (fail_set)       fail_q <= addr_q;
    end
  end

  always_comb begin
    bus_req = 1'b0;
    bus_we  = 1'b1;
    bus_wdata = CMD_READ;
    unique case (state)
      ST_ERS_A, ST_ERS_B: begin bus_req = 1'b1; bus_wdata = CMD_ERASE;  end
      ST_VFY_CMD:         begin bus_req = 1'b1; bus_wdata = CMD_VERIFY; end
      ST_VFY_RD:          begin bus_req = 1'b1; bus_we = 1'b0;          end
      ST_RDMODE:          begin bus_req = 1'b1; bus_wdata = CMD_READ;   end
      default: ;
    endcase
  end

  assign bus_addr  = addr_q;
  assign pgm_req   = (state == ST_PRG);
  assign pgm_addr  = addr_q;
  assign pgm_data  = 8'h00;
  assign done      = (state == ST_FIN);
  assign pass      = pass_q;
  assign fail_addr = fail_q;

  a_r12_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata))
    else $error("R12 bus request changed before acknowledge");

  a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("R13 done longer than one cycle");

  a_r11_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q <= PULSE_LIM)
    else $error("R11 pulse count above limit");

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_req && bus_req))
    else $error("R2 program and bus requests overlap");

  a_r2_pgm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req && !pgm_done |=> pgm_req && $stable(pgm_addr))
    else $error("R2 program request dropped early");
endmodule

// File: tb/chip_erase_seq_tb_top.sv
module chip_erase_seq_tb_top;
  localparam int DEPTH = 16;
  localparam int ERASE_CYC = 10;
  localparam int RECOV_CYC = 6;
  localparam int MAXP = 6;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, skip_preprog = 1'b0;
  logic done, pass;
  logic [AW-1:0] fail_addr, bus_addr, pgm_addr;
  logic bus_req, bus_we, pgm_req;
  logic [7:0] bus_wdata, pgm_data;
  logic [7:0] bus_rdata = 8'h00;
  logic bus_ack = 1'b0, pgm_done = 1'b0, pgm_ok = 1'b0;

  always #4 clk = ~clk;

  chip_erase_seq #(.DEPTH(DEPTH), .ERASE_CYC(ERASE_CYC), .RECOV_CYC(RECOV_CYC),
                   .MAX_PULSES(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .skip_preprog(skip_preprog),
    .done(done), .pass(pass), .fail_addr(fail_addr),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .pgm_req(pgm_req), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .pgm_done(pgm_done), .pgm_ok(pgm_ok));

  int errors = 0, checks = 0;
  int need [DEPTH];
  int pgm_fail_at;
  int pulses, idle_gap, exp_vaddr, pgm_cnt, lat, plat, n_txn;
  bit erase_arm, pulse_just, a0_pend, in_txn, saw_rdmode, first_bus, run_skip;
  int a0_addr;
  logic [7:0] snap_wd; logic [AW-1:0] snap_ad; logic snap_we;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mon_clear();
    pulses = 0; idle_gap = 0; exp_vaddr = 0; pgm_cnt = 0; lat = 0; plat = 0; n_txn = 0;
    erase_arm = 0; pulse_just = 0; a0_pend = 0; in_txn = 0; saw_rdmode = 0;
    first_bus = 1; a0_addr = -1;
  endtask

  task automatic bus_complete();
    if (in_txn)
      chk(snap_we == bus_we && snap_ad == bus_addr && (!bus_we || snap_wd == bus_wdata),
          "R12", int'(bus_addr), int'(snap_ad));
    in_txn = 0;
    n_txn++;
    if (first_bus) begin
      first_bus = 0;
      if (run_skip) chk(pgm_cnt == 0 && bus_wdata == 8'h20, "R3", pgm_cnt, 0);
      else if (pgm_fail_at >= 0) chk(pgm_cnt == pgm_fail_at + 1, "R4", pgm_cnt, pgm_fail_at + 1);
      else chk(pgm_cnt == DEPTH, "R2", pgm_cnt, DEPTH);
    end
    chk(!saw_rdmode, "R13", n_txn, 0);
    if (bus_we && bus_wdata == 8'h20) begin
      if (erase_arm) begin pulses++; erase_arm = 0; pulse_just = 1; end
      else erase_arm = 1;
    end else begin
      chk(!erase_arm, "R5", int'(bus_wdata), 32);
      erase_arm = 0;
      if (bus_we && bus_wdata == 8'hA0) begin
        if (pulse_just) begin
          chk(idle_gap == ERASE_CYC, "R6", idle_gap, ERASE_CYC);
          chk(int'(bus_addr) == exp_vaddr, "R9", int'(bus_addr), exp_vaddr);
        end else begin
          chk(int'(bus_addr) == exp_vaddr, "R8", int'(bus_addr), exp_vaddr);
        end
        pulse_just = 0; a0_pend = 1; a0_addr = int'(bus_addr);
      end else if (bus_we && bus_wdata == 8'h00) begin
        saw_rdmode = 1;
        if (pgm_fail_at >= 0 && !run_skip) chk(pulses == 0, "R4", pulses, 0);
      end else if (!bus_we) begin
        chk(a0_pend && a0_addr == int'(bus_addr) && idle_gap == RECOV_CYC, "R7", idle_gap, RECOV_CYC);
        a0_pend = 0;
        if (pulses >= need[bus_addr]) begin
          bus_rdata = 8'hFF;
          exp_vaddr = int'(bus_addr) + 1;
        end else begin
          bus_rdata = 8'($urandom_range(0, 254));
        end
      end else begin
        chk(0, "R5", int'(bus_wdata), 0);
      end
    end
    idle_gap = 0;
  endtask

  always @(negedge clk) begin
    bit was_ack, was_pdone;
    if (rst_n) begin
      was_ack = bus_ack; bus_ack = 0;
      if (!bus_req) idle_gap++;
      else if (!was_ack) begin
        if (!in_txn) begin in_txn = 1; snap_we = bus_we; snap_ad = bus_addr; snap_wd = bus_wdata; end
        if (lat == 0) begin bus_complete(); bus_ack = 1; lat = $urandom_range(0, 3); end
        else lat--;
      end
      was_pdone = pgm_done; pgm_done = 0;
      if (pgm_req && !was_pdone) begin
        if (plat == 0) begin
          chk(int'(pgm_addr) == pgm_cnt && pgm_data == 8'h00 && !run_skip, "R2", int'(pgm_addr), pgm_cnt);
          pgm_ok = (int'(pgm_addr) != pgm_fail_at);
          pgm_cnt++; pgm_done = 1; plat = $urandom_range(0, 4);
        end else plat--;
      end
    end
  end

  task automatic run_case(input bit skip, input int pfail);
    int p, ep, efail; bit epass; int wd;
    run_skip = skip; pgm_fail_at = pfail;
    @(negedge clk); #1;
    mon_clear();
    skip_preprog = skip; start = 1;
    @(negedge clk); #1; start = 0;
    epass = 1; efail = 0; p = 1;
    if (pfail >= 0 && !skip) begin epass = 0; efail = pfail; p = 0; end
    else for (int a = 0; a < DEPTH; a++) begin
      if (need[a] > p) begin
        if (need[a] > MAXP) begin p = MAXP; epass = 0; efail = a; break; end
        p = need[a];
      end
    end
    ep = p;
    wd = 0;
    while (!done && wd < 20000) begin @(negedge clk); #1; wd++; end
    if (wd >= 20000) begin chk(0, "watchdog", wd, 0); return; end
    chk(saw_rdmode, "R13", 0, 1);
    if (epass) chk(pass == 1'b1, "R10", int'(pass), 1);
    else chk(pass == 1'b0 && int'(fail_addr) == efail, (pfail >= 0) ? "R4" : "R11",
             int'(fail_addr), efail);
    chk(pulses == ep && pulses <= MAXP, "R11", pulses, ep);
    @(negedge clk); #1;
    chk(!done, "R13", int'(done), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    mon_clear(); run_skip = 0; pgm_fail_at = -1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!done && !pass && !bus_req && !pgm_req, "R1", int'(bus_req), 0);
    // all bytes erase on first pulse, with preprogram
    for (int a = 0; a < DEPTH; a++) need[a] = 1;
    run_case(0, -1);
    // skip preprogram, first byte slow: resume at address 0
    for (int a = 0; a < DEPTH; a++) need[a] = 1;
    need[0] = 3;
    run_case(1, -1);
    // last byte needs exactly the limit
    for (int a = 0; a < DEPTH; a++) need[a] = 1;
    need[DEPTH-1] = MAXP;
    run_case(1, -1);
    // byte beyond the limit
    for (int a = 0; a < DEPTH; a++) need[a] = 2;
    need[9] = MAXP + 1;
    run_case(0, -1);
    // program failure mid-array
    run_case(0, 5);
    // program failure at first byte
    run_case(0, 0);
    // random patterns
    for (int it = 0; it < 10; it++) begin
      for (int a = 0; a < DEPTH; a++) need[a] = $urandom_range(1, MAXP + ((it % 3 == 2) ? 1 : 0));
      run_case(bit'($urandom_range(0, 1)), -1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule